// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 64-bit integers over many clocks, retiring one partial product per cycle. It holds the multiplicand in a side register and keeps a 128-bit working product register whose lower half starts out as the multiplier. On every iteration the low bit of that register decides whether the multiplicand is added to the upper half. The sum, including its carry-out, and the remaining bits then move one place to the right in the same clock. After 64 iterations the register holds the full double-width product.

A one-cycle request on `start_i` launches an operation. It carries the two operands and a 2-bit result selector, and is accepted only while the block is idle. The selector picks the low word, the high word under a signed view, or the high word under an unsigned view. For the signed view the datapath multiplies the operand magnitudes and negates the 128-bit product if the operand signs differ. A one-cycle `done_o` pulse marks the result as ready, and `result_o` then holds its value until the next operation completes.

The controller has three states. `ST_IDLE` waits for a request. `ST_ITER` runs the 64 add-and-shift steps. `ST_FIX` applies the sign correction and registers the chosen word. The transitions are as follows:
- `ST_IDLE` goes to `ST_ITER` on a request.
- `ST_ITER` stays in `ST_ITER` until the step counter reaches its last value, then goes to `ST_FIX`.
- `ST_FIX` always returns to `ST_IDLE`.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held, and after it is released, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: Selector code 2'b00 returns bits [63:0] of the 128-bit product of the operands.
- R3: Selector code 2'b01 returns bits [127:64] of the product, with both operands read as two's-complement signed values.
- R4: Selector code 2'b10 returns bits [127:64] of the product, with both operands read as unsigned values.
- R5: Selector code 2'b11 behaves the same as code 2'b00.
- R6: After a request is accepted at a clock edge, `busy_o` is high for exactly 65 cycles: 64 iteration cycles plus one sign-fix cycle.
- R7: `done_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is low after an operation.
- R8: A request made while `busy_o` is high is ignored, so the running operation completes with its original operands and selector.
- R9: `result_o` changes only at the edge that raises `done_o`, and otherwise holds its value, including while a later operation runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to launch an operation |
| sel_i | input | 2 | Result selector (see R2 to R5) |
| opa_i | input | 64 | Multiplicand operand |
| opb_i | input | 64 | Multiplier operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Selected 64-bit word of the product |

## Verification
The operand table is chosen to separate the signed and unsigned views of the high word:
- Zero and one set the trivial floor.
- All-ones reads as -1 in the signed view but as the largest value in the unsigned view.
- The most negative value, against itself and against -1, pushes the magnitude path to its only operand whose negation is not representable.
- A pair of mixed-sign operands shows whether the final negation is applied.
- A pair of large unsigned operands makes the adder carry-out reach the top bit.

Every table row runs under all four selector codes. Directed tests then count the busy cycles, try a request in the middle of an operation with different operands, and watch `result_o` during the idle gap and during the following operation.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        SEL_LO  = 2'b00,
        SEL_SHI = 2'b01,
        SEL_UHI = 2'b10,
        SEL_LO2 = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ITER = 2'b01,
        ST_FIX  = 2'b10
    } st_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
    parameter int W = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o,
    output logic done_o
);
    import smul_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    st_e           state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // state register, step counter and registered completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIX);
            if (state_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)      state_d = ST_ITER;
            ST_ITER: if (cnt_q == LAST) state_d = ST_FIX;
            ST_FIX:                     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        fix_o  = 1'b0;
        busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_ITER: begin step_o = 1'b1; busy_o = 1'b1; end
            ST_FIX:  begin fix_o  = 1'b1; busy_o = 1'b1; end
            default: ;
        endcase
    end

    assign done_o = done_q;
endmodule

// File: rtl/smul_mag.sv
module smul_mag #(
    parameter int W = 64
) (
    input  logic         signed_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    // the negation of the most negative value wraps to 2^(W-1), which is
    // the correct magnitude when read as unsigned
    assign neg_o = signed_i & val_i[W-1];
    assign mag_o = neg_o ? (~val_i + 1'b1) : val_i;
endmodule

// File: rtl/smul_dp.sv
module smul_dp #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         fix_i,
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o
);
    import smul_pkg::*;

    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic          neg_q;
    sel_e          sel_q;
    logic [W-1:0]  res_q;

    logic              sgn;
    logic [1:0][W-1:0] mag;
    logic [1:0]        negs;
    logic [W:0]        sum;
    logic [PW-1:0]     fixed;

    assign sgn = (sel_e'(sel_i) == SEL_SHI);

    for (genvar i = 0; i < 2; i++) begin : g_mag
        smul_mag #(.W(W)) u_mag (
            .signed_i (sgn),
            .val_i    ((i == 0) ? opa_i : opb_i),
            .mag_o    (mag[i]),
            .neg_o    (negs[i])
        );
    end

    // add the multiplicand into the upper half; the carry becomes bit W
    assign sum   = {1'b0, prod_q[PW-1:W]} + {1'b0, (prod_q[0] ? mcand_q : {W{1'b0}})};
    assign fixed = neg_q ? (~prod_q + 1'b1) : prod_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
            neg_q   <= 1'b0;
            sel_q   <= SEL_LO;
            res_q   <= '0;
        end else if (load_i) begin
            mcand_q <= mag[0];
            prod_q  <= {{W{1'b0}}, mag[1]};
            neg_q   <= negs[0] ^ negs[1];
            sel_q   <= sel_e'(sel_i);
        end else if (step_i) begin
            prod_q  <= {sum, prod_q[W-1:1]};
        end else if (fix_i) begin
            unique case (sel_q)
                SEL_SHI: res_q <= fixed[PW-1:W];
                SEL_UHI: res_q <= prod_q[PW-1:W];
                default: res_q <= prod_q[W-1:0];
            endcase
        end
    end

    assign result_o = res_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    logic load, step, fix;

    smul_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .fix_o   (fix),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    smul_dp #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .fix_i    (fix),
        .sel_i    (sel_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .result_o (result_o)
    );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    localparam int BUSY_LEN = W + 1;
    localparam int KW = $clog2(BUSY_LEN + 1) + 1;

    logic [KW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o)) |-> ($past(busy_cnt) == KW'(BUSY_LEN - 1)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

bind shift_add_mul smul_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;
    localparam int W = 64;
    localparam int NV = 8;
    localparam logic [W-1:0] TA [NV] = '{
        64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
        64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF9, 64'hF0F0_1234_5678_9ABC,
        64'h0000_0001_0000_0003};
    localparam logic [W-1:0] TB [NV] = '{
        64'h1234_5678_9ABC_DEF0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0005, 64'hE123_4567_89AB_CDEF,
        64'h7FFF_FFFF_FFFF_FFFF};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   sel_i = 2'b00;
    logic [W-1:0] opa_i = '0, opb_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    shift_add_mul #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    function automatic logic [W-1:0] expect_val(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] s);
        logic [2*W-1:0] pu, ps;
        pu = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        ps = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        case (s)
            2'b01:   return ps[2*W-1:W];
            2'b10:   return pu[2*W-1:W];
            default: return pu[W-1:0];
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one operation: returns result and the count of edges from accept to done
    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] s,
                          output logic [W-1:0] res, output int lat);
        @(negedge clk);
        opa_i = a; opb_i = b; sel_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        res = result_o;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] res, held;
        int lat, bcnt;
        string tag;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy", W'(busy_o), '0);
        check("R1 done", W'(done_o), '0);
        check("R1 result", result_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", W'(busy_o), '0);

        // table walk, all selector codes: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 4; s++) begin
                run_op(TA[v], TB[v], 2'(s), res, lat);
                tag = (s == 0) ? "R2 low" : (s == 1) ? "R3 signed high" :
                      (s == 2) ? "R4 unsigned high" : "R5 code3 low";
                check(tag, res, expect_val(TA[v], TB[v], 2'(s)));
            end
        end

        // R6 busy length and R7 done timing
        @(negedge clk);
        opa_i = 64'd12345; opb_i = 64'd678; sel_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        bcnt = 0;
        while (busy_o && bcnt < 300) begin
            bcnt++;
            check("R7 no done while busy", W'(done_o), '0);
            @(negedge clk);
        end
        check("R6 busy cycles", W'(bcnt), W'(65));
        check("R7 done in first idle cycle", W'(done_o), W'(1));
        check("R2 low small", result_o, 64'd12345 * 64'd678);
        held = result_o;
        @(negedge clk);
        check("R7 done single cycle", W'(done_o), '0);

        // R9 result held while idle
        repeat (5) @(negedge clk);
        check("R9 held idle", result_o, held);

        // R8 request mid-operation ignored; R9 held during next operation
        @(negedge clk);
        opa_i = 64'hFFFF_FFFF_FFFF_FFFE; opb_i = 64'd3; sel_i = 2'b01; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 held during run", result_o, held);
        opa_i = 64'd99; opb_i = 64'd99; sel_i = 2'b10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 300) begin @(negedge clk); lat++; end
        check("R8 original ops kept", result_o,
              expect_val(64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 2'b01));
        @(negedge clk);
        check("R8 no second op", W'(busy_o), '0);

        finish_run();
    end
endmodule